// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This controller takes one memory access at a time and works out which translation stages it needs. The inputs that decide this are the access kind, the hypervisor-state bit and the two relocation enables. The controller then runs those stages through an external table-walk engine. It never reads memory itself. Every lookup is sent to the walk engine as one request of one of three kinds:

- a partition-scoped translation of an address;
- a read of a process-table entry;
- a read of one level of the process-scoped directory tree.

The controller works out the process-table entry address from the table base, the process ID and the table size field. It rejects IDs that fall outside the table. It folds each stage's page size and permissions into the final result.

When a guest runs with relocation on, the walks are nested. The process-table entry address is translated by the partition stage before the entry is read. So is each guest directory address before that level is read. After the leaf, the resulting guest real address gets one final partition translation. A walk-engine fault ends the sequence at once, and the controller reports which stage failed.

Top module: `xlt2_seq`

## Requirements
- R1: Relocation applies when a fetch (`req_kind`=2) has `req_ir` set, or when a load (0) or a store (1) has `req_dr` set. The other relocation bit is ignored.
- R2: With `req_hv`=1 and relocation off, no walk request is issued. The result pulses `done` in the cycle after acceptance, with `res_addr` equal to `req_ea` with its top 4 bits cleared, `res_perm`=3'b111 and `res_psize`=63.
- R3: With `req_hv`=1 and relocation on, only process-scoped requests are issued. First comes a table-entry read (`wk_op`=1) at `ptbl_base + req_pid*16`, then directory-level reads (`wk_op`=2). The leaf's address is the result.
- R4: With `req_hv`=0 and relocation off, exactly one partition walk (`wk_op`=0) is issued, at `req_ea` with its top 2 bits cleared. Its response address is the result.
- R5: With `req_hv`=0 and relocation on, the requests run in this order:
  - a partition walk of the entry address;
  - the entry read;
  - for each level, a partition walk followed by a level read;
  - a final partition walk of the leaf address.
- R6: If `req_pid*16` is at or beyond 2^(`ptbl_size`+12), the request faults with `flt_proc`=1 and `flt_bound`=1, and no walk request is issued.
- R7: The result page size is the minimum of the leaf and final-partition sizes that apply, starting from 63. The result permissions (bit0 read, bit1 write, bit2 execute) are the AND of those that apply, starting from 3'b111.
- R8: A walk response with `wk_rsp_fault` set ends the sequence with a `fault` pulse and no further requests. `flt_proc` is 1 for entry and level reads. `flt_table` is 1 when a partition walk of a table or directory address failed.
- R9: A non-leaf response at the fourth directory level ends the sequence with a process-stage fault.
- R10: One request is handled at a time:
  - `busy` rises after acceptance and stays high through a single-cycle `done` or `fault` pulse;
  - `req_valid` is ignored while busy;
  - each walk request is a one-cycle `wk_req_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New access offered (taken when not busy) |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_hv | input | 1 | Hypervisor state |
| req_ir | input | 1 | Instruction relocation enable |
| req_dr | input | 1 | Data relocation enable |
| req_ea | input | AW | Effective address |
| req_lpid | input | LPID_W | Partition ID, passed to the walk engine |
| req_pid | input | PID_W | Process ID |
| ptbl_base | input | AW | Process-table base address |
| ptbl_size | input | SZ_W | Table size field, size = 2^(field+12) bytes |
| wk_req_valid | output | 1 | Walk request pulse |
| wk_op | output | 2 | 0 partition walk, 1 entry read, 2 level read |
| wk_addr | output | AW | Address to walk or read |
| wk_ea | output | AW | Masked effective address for indexing |
| wk_lpid | output | LPID_W | Partition ID of the access |
| wk_rsp_valid | input | 1 | Walk response pulse |
| wk_rsp_fault | input | 1 | Walk failed |
| wk_rsp_leaf | input | 1 | Level read hit a leaf |
| wk_rsp_addr | input | AW | Translated address, entry root or next/leaf address |
| wk_rsp_psize | input | PS_W | Log2 page size of this stage |
| wk_rsp_perm | input | 3 | Permissions of this stage |
| busy | output | 1 | Access in progress |
| done | output | 1 | Success pulse |
| fault | output | 1 | Fault pulse |
| res_addr | output | AW | Final real address |
| res_psize | output | PS_W | Final log2 page size |
| res_perm | output | 3 | Final permissions |
| flt_proc | output | 1 | Fault came from the process stage |
| flt_table | output | 1 | Partition fault on a table or directory address |
| flt_bound | output | 1 | Process ID beyond the table |

## Verification
A wrong phase register shows up straight away on `wk_op`, on the very next walk request. So every test compares the logged operation sequence against the order expected for its mode. A stale address register is caught by comparing the first request's address and the final `res_addr`. A lost or extra state transition shows up as a wrong request count, or as a `done`/`fault` pulse that is late, missing or longer than one cycle. Each of these is checked after every access.

// File: rtl/xlt2_pkg.sv
package xlt2_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        WK_PART  = 2'd0,
        WK_PTBL  = 2'd1,
        WK_LEVEL = 2'd2
    } wk_op_e;

    typedef enum logic [1:0] {
        MD_NONE,
        MD_PART,
        MD_PROC,
        MD_BOTH
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_RESP
    } st_e;

    typedef enum logic [2:0] {
        PH_TBL_XL,
        PH_TBL_RD,
        PH_DIR_XL,
        PH_DIR_RD,
        PH_FINAL
    } ph_e;

endpackage

// File: rtl/xlt2_mode_dec.sv
module xlt2_mode_dec
    import xlt2_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       hv,
    input  logic       ir,
    input  logic       dr,
    output logic       reloc,
    output mode_e      mode
);
    always_comb begin
        reloc = (kind == ACC_FETCH) ? ir : dr;
        if (hv) mode = reloc ? MD_PROC : MD_NONE;
        else    mode = reloc ? MD_BOTH : MD_PART;
    end
endmodule

// File: rtl/xlt2_ptbl_idx.sv
module xlt2_ptbl_idx #(
    parameter int AW         = 64,
    parameter int PID_W      = 20,
    parameter int SZ_W       = 5,
    parameter int ENT_SHIFT  = 4,
    parameter int BASE_SHIFT = 12
) (
    input  logic [AW-1:0]    base,
    input  logic [PID_W-1:0] pid,
    input  logic [SZ_W-1:0]  size_fld,
    output logic [AW-1:0]    ent_addr,
    output logic             over
);
    localparam logic [7:0] AW8 = 8'(AW);
    localparam logic [7:0] BS8 = 8'(BASE_SHIFT);

    logic [AW-1:0] offset;
    logic [7:0]    lim;

    always_comb begin
        offset   = {{(AW-PID_W){1'b0}}, pid} << ENT_SHIFT;
        lim      = 8'(size_fld) + BS8;
        over     = (lim >= AW8) ? 1'b0 : ((offset >> lim) != '0);
        ent_addr = base + offset;
    end
endmodule

// File: rtl/xlt2_merge.sv
module xlt2_merge #(
    parameter int PS_W = 6
) (
    input  logic [PS_W-1:0] ps_a,
    input  logic [PS_W-1:0] ps_b,
    input  logic [2:0]      perm_a,
    input  logic [2:0]      perm_b,
    output logic [PS_W-1:0] ps_o,
    output logic [2:0]      perm_o
);
    always_comb begin
        ps_o   = (ps_a < ps_b) ? ps_a : ps_b;
        perm_o = perm_a & perm_b;
    end
endmodule

// File: rtl/xlt2_seq.sv
module xlt2_seq
    import xlt2_pkg::*;
#(
    parameter int AW      = 64,
    parameter int LPID_W  = 12,
    parameter int PID_W   = 20,
    parameter int SZ_W    = 5,
    parameter int PS_W    = 6,
    parameter int MAX_LVL = 4,
    parameter int RM_IGN  = 4,
    parameter int GRA_IGN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_hv,
    input  logic              req_ir,
    input  logic              req_dr,
    input  logic [AW-1:0]     req_ea,
    input  logic [LPID_W-1:0] req_lpid,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [AW-1:0]     ptbl_base,
    input  logic [SZ_W-1:0]   ptbl_size,
    output logic              wk_req_valid,
    output logic [1:0]        wk_op,
    output logic [AW-1:0]     wk_addr,
    output logic [AW-1:0]     wk_ea,
    output logic [LPID_W-1:0] wk_lpid,
    input  logic              wk_rsp_valid,
    input  logic              wk_rsp_fault,
    input  logic              wk_rsp_leaf,
    input  logic [AW-1:0]     wk_rsp_addr,
    input  logic [PS_W-1:0]   wk_rsp_psize,
    input  logic [2:0]        wk_rsp_perm,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [AW-1:0]     res_addr,
    output logic [PS_W-1:0]   res_psize,
    output logic [2:0]        res_perm,
    output logic              flt_proc,
    output logic              flt_table,
    output logic              flt_bound
);
    localparam int            LV_W     = (MAX_LVL > 2) ? $clog2(MAX_LVL) : 1;
    localparam logic [LV_W-1:0] LV_LAST = LV_W'(MAX_LVL - 1);
    localparam logic [AW-1:0] RM_MASK  = {AW{1'b1}} >> RM_IGN;
    localparam logic [AW-1:0] GRA_MASK = {AW{1'b1}} >> GRA_IGN;

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic              hv;
        logic [AW-1:0]     ea;
        logic [LPID_W-1:0] lpid;
        logic [AW-1:0]     addr;
        logic [LV_W-1:0]   lvl;
        logic [PS_W-1:0]   ps;
        logic [2:0]        perm;
        logic              flt;
        logic              f_proc;
        logic              f_tbl;
        logic              f_bnd;
    } seq_t;

    seq_t q, d;

    logic            dec_reloc;
    mode_e           dec_mode;
    logic [AW-1:0]   ent_addr;
    logic            ent_over;
    logic [PS_W-1:0] m_ps;
    logic [2:0]      m_perm;

    xlt2_mode_dec u_dec (
        .kind (req_kind),
        .hv   (req_hv),
        .ir   (req_ir),
        .dr   (req_dr),
        .reloc(dec_reloc),
        .mode (dec_mode)
    );

    xlt2_ptbl_idx #(.AW(AW), .PID_W(PID_W), .SZ_W(SZ_W)) u_idx (
        .base    (ptbl_base),
        .pid     (req_pid),
        .size_fld(ptbl_size),
        .ent_addr(ent_addr),
        .over    (ent_over)
    );

    xlt2_merge #(.PS_W(PS_W)) u_merge (
        .ps_a  (q.ps),
        .ps_b  (wk_rsp_psize),
        .perm_a(q.perm),
        .perm_b(wk_rsp_perm),
        .ps_o  (m_ps),
        .perm_o(m_perm)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.hv     = req_hv;
                    d.ea     = req_ea & GRA_MASK;
                    d.lpid   = req_lpid;
                    d.ps     = '1;
                    d.perm   = 3'b111;
                    d.lvl    = '0;
                    d.flt    = 1'b0;
                    d.f_proc = 1'b0;
                    d.f_tbl  = 1'b0;
                    d.f_bnd  = 1'b0;
                    case (dec_mode)
                        MD_NONE: begin
                            d.addr = req_ea & RM_MASK;
                            d.st   = S_RESP;
                        end
                        MD_PART: begin
                            d.addr = req_ea & GRA_MASK;
                            d.ph   = PH_FINAL;
                            d.st   = S_ISSUE;
                        end
                        default: begin
                            if (ent_over) begin
                                d.addr   = '0;
                                d.flt    = 1'b1;
                                d.f_proc = 1'b1;
                                d.f_bnd  = 1'b1;
                                d.st     = S_RESP;
                            end else begin
                                d.addr = ent_addr;
                                d.ph   = req_hv ? PH_TBL_RD : PH_TBL_XL;
                                d.st   = S_ISSUE;
                            end
                        end
                    endcase
                end
            end
            S_ISSUE: d.st = S_WAIT;
            S_WAIT: begin
                if (wk_rsp_valid) begin
                    if (wk_rsp_fault) begin
                        d.flt    = 1'b1;
                        d.f_proc = (q.ph == PH_TBL_RD) || (q.ph == PH_DIR_RD);
                        d.f_tbl  = (q.ph == PH_TBL_XL) || (q.ph == PH_DIR_XL);
                        d.st     = S_RESP;
                    end else begin
                        d.addr = wk_rsp_addr;
                        d.st   = S_ISSUE;
                        case (q.ph)
                            PH_TBL_XL: d.ph = PH_TBL_RD;
                            PH_TBL_RD: d.ph = q.hv ? PH_DIR_RD : PH_DIR_XL;
                            PH_DIR_XL: d.ph = PH_DIR_RD;
                            PH_DIR_RD: begin
                                if (wk_rsp_leaf) begin
                                    d.ps   = m_ps;
                                    d.perm = m_perm;
                                    d.ph   = PH_FINAL;
                                    if (q.hv) d.st = S_RESP;
                                end else if (q.lvl == LV_LAST) begin
                                    d.flt    = 1'b1;
                                    d.f_proc = 1'b1;
                                    d.st     = S_RESP;
                                end else begin
                                    d.lvl = q.lvl + LV_W'(1);
                                    d.ph  = q.hv ? PH_DIR_RD : PH_DIR_XL;
                                end
                            end
                            default: begin
                                d.ps   = m_ps;
                                d.perm = m_perm;
                                d.st   = S_RESP;
                            end
                        endcase
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.ph)
            PH_TBL_RD: wk_op = WK_PTBL;
            PH_DIR_RD: wk_op = WK_LEVEL;
            default:   wk_op = WK_PART;
        endcase
        wk_req_valid = (q.st == S_ISSUE);
        wk_addr      = q.addr;
        wk_ea        = q.ea;
        wk_lpid      = q.lpid;
        busy         = (q.st != S_IDLE);
        done         = (q.st == S_RESP) && !q.flt;
        fault        = (q.st == S_RESP) && q.flt;
        res_addr     = q.addr;
        res_psize    = q.ps;
        res_perm     = q.perm;
        flt_proc     = q.f_proc;
        flt_table    = q.f_tbl;
        flt_bound    = q.f_bnd;
    end

endmodule

// File: rtl/xlt2_seq_chk.sv
module xlt2_seq_chk #(
    parameter int AW     = 64,
    parameter int PS_W   = 6,
    parameter int RM_IGN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic            req_hv,
    input logic            req_ir,
    input logic            req_dr,
    input logic [AW-1:0]   req_ea,
    input logic            wk_req_valid,
    input logic            busy,
    input logic            done,
    input logic            fault,
    input logic [AW-1:0]   res_addr,
    input logic [PS_W-1:0] res_psize,
    input logic [2:0]      res_perm,
    input logic            flt_proc,
    input logic            flt_bound
);
    localparam logic [AW-1:0] RM_MASK = {AW{1'b1}} >> RM_IGN;

    logic rl;
    assign rl = (req_kind == 2'd2) ? req_ir : req_dr;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault)); // R10
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R8
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !fault) |=> busy); // R10
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy); // R10
    AST_IDLE_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wk_req_valid); // R10
    AST_WALK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wk_req_valid |=> !wk_req_valid); // R10
    AST_REAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_hv && !rl) |=>
        (done && res_addr == ($past(req_ea) & RM_MASK) &&
         res_perm == 3'b111 && res_psize == {PS_W{1'b1}})); // R2
    AST_BOUND_PROC: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && flt_bound) |-> flt_proc); // R6
endmodule

bind xlt2_seq xlt2_seq_chk #(.AW(AW), .PS_W(PS_W), .RM_IGN(RM_IGN)) u_chk (.*);

// File: tb/tb_xlt2_seq.sv
module tb_xlt2_seq;
    localparam logic [63:0] PART_OFS = 64'h1_0000_0000;
    localparam logic [63:0] BASE     = 64'h10_0000;

    typedef struct packed {
        logic [1:0]  kind;
        logic        hv, ir, dr;
        logic [63:0] ea;
        logic [19:0] pid;
        logic [4:0]  prts;
        logic [3:0]  leaf_at;
        logic [2:0]  part_perm, proc_perm;
        logic [5:0]  part_ps, proc_ps;
        logic [3:0]  flt_idx;
        logic        e_flt, e_proc, e_tbl, e_bnd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b1,1'b0,1'b0,64'hF123_4567_89AB_CDEF,20'd0,5'd0,4'd1,3'd7,3'd7,6'd30,6'd30,4'd15,1'b0,1'b0,1'b0,1'b0},
        '{2'd2,1'b1,1'b1,1'b0,64'hF123_4567_89AB_CDEF,20'd3,5'd0,4'd2,3'd7,3'd5,6'd30,6'd21,4'd15,1'b0,1'b0,1'b0,1'b0},
        '{2'd0,1'b1,1'b1,1'b0,64'hF123_4567_89AB_CDEF,20'd3,5'd0,4'd2,3'd7,3'd5,6'd30,6'd21,4'd15,1'b0,1'b0,1'b0,1'b0},
        '{2'd1,1'b0,1'b0,1'b0,64'hC000_0000_0000_1234,20'd0,5'd0,4'd1,3'd3,3'd7,6'd16,6'd30,4'd15,1'b0,1'b0,1'b0,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd5,5'd1,4'd3,3'd6,3'd3,6'd24,6'd12,4'd15,1'b0,1'b0,1'b0,1'b0},
        '{2'd2,1'b0,1'b1,1'b0,64'h0000_0000_0040_0ABC,20'd1,5'd0,4'd1,3'd5,3'd7,6'd12,6'd30,4'd15,1'b0,1'b0,1'b0,1'b0},
        '{2'd0,1'b1,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd256,5'd0,4'd1,3'd7,3'd7,6'd30,6'd30,4'd15,1'b1,1'b1,1'b0,1'b1},
        '{2'd0,1'b1,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd255,5'd0,4'd1,3'd7,3'd6,6'd30,6'd21,4'd15,1'b0,1'b0,1'b0,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd2,5'd0,4'd2,3'd7,3'd7,6'd30,6'd30,4'd0,1'b1,1'b0,1'b1,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd2,5'd0,4'd2,3'd7,3'd7,6'd30,6'd30,4'd1,1'b1,1'b1,1'b0,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd2,5'd0,4'd1,3'd7,3'd7,6'd30,6'd30,4'd4,1'b1,1'b0,1'b0,1'b0},
        '{2'd1,1'b0,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd2,5'd0,4'd2,3'd7,3'd7,6'd30,6'd30,4'd3,1'b1,1'b1,1'b0,1'b0},
        '{2'd0,1'b1,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd2,5'd0,4'd5,3'd7,3'd7,6'd30,6'd30,4'd15,1'b1,1'b1,1'b0,1'b0},
        '{2'd1,1'b0,1'b0,1'b0,64'hF123_4567_89AB_CDEF,20'd2,5'd0,4'd1,3'd7,3'd7,6'd30,6'd30,4'd0,1'b1,1'b0,1'b0,1'b0},
        '{2'd0,1'b0,1'b0,1'b1,64'hF123_4567_89AB_CDEF,20'd2,5'd0,4'd5,3'd7,3'd7,6'd30,6'd30,4'd15,1'b1,1'b1,1'b0,1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_hv = 1'b0, req_ir = 1'b0, req_dr = 1'b0;
    logic [63:0] req_ea = '0;
    logic [11:0] req_lpid = 12'h5;
    logic [19:0] req_pid = '0;
    logic [63:0] ptbl_base = BASE;
    logic [4:0]  ptbl_size = '0;
    logic        wk_req_valid;
    logic [1:0]  wk_op;
    logic [63:0] wk_addr, wk_ea;
    logic [11:0] wk_lpid;
    logic        rsp_v = 1'b0, rsp_flt = 1'b0, rsp_leaf = 1'b0;
    logic [63:0] rsp_addr = '0;
    logic [5:0]  rsp_ps = '0;
    logic [2:0]  rsp_perm = '0;
    logic        busy, done, fault;
    logic [63:0] res_addr;
    logic [5:0]  res_psize;
    logic [2:0]  res_perm;
    logic        flt_proc, flt_table, flt_bound;

    xlt2_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_hv(req_hv), .req_ir(req_ir), .req_dr(req_dr), .req_ea(req_ea),
        .req_lpid(req_lpid), .req_pid(req_pid), .ptbl_base(ptbl_base),
        .ptbl_size(ptbl_size), .wk_req_valid(wk_req_valid), .wk_op(wk_op),
        .wk_addr(wk_addr), .wk_ea(wk_ea), .wk_lpid(wk_lpid),
        .wk_rsp_valid(rsp_v), .wk_rsp_fault(rsp_flt), .wk_rsp_leaf(rsp_leaf),
        .wk_rsp_addr(rsp_addr), .wk_rsp_psize(rsp_ps), .wk_rsp_perm(rsp_perm),
        .busy(busy), .done(done), .fault(fault), .res_addr(res_addr),
        .res_psize(res_psize), .res_perm(res_perm), .flt_proc(flt_proc),
        .flt_table(flt_table), .flt_bound(flt_bound)
    );

    // walk engine model
    logic        clr = 1'b0;
    int          tb_leaf = 1, tb_flt = 15;
    logic [2:0]  tb_part_perm = 3'd7, tb_proc_perm = 3'd7;
    logic [5:0]  tb_part_ps = 6'd30, tb_proc_ps = 6'd30;
    int          nops, resp_idx, lvl_cnt, dly;
    logic        pend;
    logic [1:0]  p_op;
    logic [63:0] p_addr, p_ea;
    logic [1:0]  log_op [16];
    logic [63:0] log_addr [16];

    always @(posedge clk) begin
        rsp_v <= 1'b0;
        if (!rst_n || clr) begin
            pend <= 1'b0; nops <= 0; resp_idx <= 0; lvl_cnt <= 0; dly <= 0;
        end else if (wk_req_valid) begin
            pend <= 1'b1; dly <= 1; p_op <= wk_op; p_addr <= wk_addr; p_ea <= wk_ea;
            if (nops < 16) begin
                log_op[nops]   <= wk_op;
                log_addr[nops] <= wk_addr;
            end
            nops <= nops + 1;
        end else if (pend) begin
            if (dly != 0) dly <= dly - 1;
            else begin
                pend <= 1'b0; rsp_v <= 1'b1; resp_idx <= resp_idx + 1;
                rsp_flt <= (resp_idx == tb_flt);
                rsp_leaf <= 1'b0; rsp_ps <= '0; rsp_perm <= '0;
                case (p_op)
                    2'd0: begin
                        rsp_addr <= p_addr + PART_OFS;
                        rsp_ps <= tb_part_ps; rsp_perm <= tb_part_perm;
                    end
                    2'd1: rsp_addr <= 64'h2000;
                    default: begin
                        lvl_cnt <= lvl_cnt + 1;
                        if (lvl_cnt + 1 == tb_leaf) begin
                            rsp_leaf <= 1'b1;
                            rsp_addr <= 64'h50_0000 | (p_ea & 64'hFFF);
                            rsp_ps <= tb_proc_ps; rsp_perm <= tb_proc_perm;
                        end else rsp_addr <= p_addr + 64'h100;
                    end
                endcase
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit rl_of(vec_t v);
        return (v.kind == 2'd2) ? v.ir : v.dr;
    endfunction

    function automatic string mode_tag(vec_t v);
        if (v.hv) return rl_of(v) ? "R3" : "R2";
        return rl_of(v) ? "R5" : "R4";
    endfunction

    function automatic logic [63:0] exp_addr(vec_t v);
        logic [63:0] leaf = 64'h50_0000 | (v.ea & 64'hFFF);
        if (v.hv) return rl_of(v) ? leaf : (v.ea & 64'h0FFF_FFFF_FFFF_FFFF);
        return rl_of(v) ? leaf + PART_OFS : (v.ea & 64'h3FFF_FFFF_FFFF_FFFF) + PART_OFS;
    endfunction

    function automatic logic [5:0] exp_ps(vec_t v);
        if (v.hv) return rl_of(v) ? v.proc_ps : 6'd63;
        if (!rl_of(v)) return v.part_ps;
        return (v.part_ps < v.proc_ps) ? v.part_ps : v.proc_ps;
    endfunction

    function automatic logic [2:0] exp_perm(vec_t v);
        if (v.hv) return rl_of(v) ? v.proc_perm : 3'd7;
        return rl_of(v) ? (v.part_perm & v.proc_perm) : v.part_perm;
    endfunction

    function automatic int exp_nops(vec_t v);
        if (v.e_bnd) return 0;
        if (v.flt_idx != 4'd15) return int'(v.flt_idx) + 1;
        if (v.leaf_at > 4'd4) return v.hv ? 5 : 10;
        if (v.hv) return rl_of(v) ? 1 + int'(v.leaf_at) : 0;
        return rl_of(v) ? 3 + 2 * int'(v.leaf_at) : 1;
    endfunction

    function automatic logic [1:0] exp_op(vec_t v, int i);
        if (v.hv) return (i == 0) ? 2'd1 : 2'd2;
        if (!rl_of(v)) return 2'd0;
        if (i == 1) return 2'd1;
        if (i == 0 || i == 2 + 2 * int'(v.leaf_at)) return 2'd0;
        return (i % 2 == 0) ? 2'd0 : 2'd2;
    endfunction

    task automatic run_vec(input int k);
        vec_t v = VECS[k];
        int   cyc = 0;
        @(negedge clk);
        clr = 1'b1;
        tb_leaf = int'(v.leaf_at); tb_flt = int'(v.flt_idx);
        tb_part_perm = v.part_perm; tb_proc_perm = v.proc_perm;
        tb_part_ps = v.part_ps; tb_proc_ps = v.proc_ps;
        @(negedge clk);
        clr = 1'b0;
        req_kind = v.kind; req_hv = v.hv; req_ir = v.ir; req_dr = v.dr;
        req_ea = v.ea; req_pid = v.pid; ptbl_size = v.prts; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!(done || fault) && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc < 200, "R10 completion", 64'(cyc), 64'd0);
        check(fault == v.e_flt, v.e_bnd ? "R6 fault" : "R8 fault", 64'(fault), 64'(v.e_flt));
        check(nops == exp_nops(v), "R1 walk count", 64'(nops), 64'(exp_nops(v)));
        for (int i = 0; i < nops && i < 16; i++)
            check(log_op[i] == exp_op(v, i), mode_tag(v), 64'(log_op[i]), 64'(exp_op(v, i)));
        if (nops > 0) begin
            if (rl_of(v))
                check(log_addr[0] == BASE + 64'(v.pid) * 16, "R3 entry addr", log_addr[0], BASE + 64'(v.pid) * 16);
            else
                check(log_addr[0] == (v.ea & 64'h3FFF_FFFF_FFFF_FFFF), "R4 walk addr", log_addr[0], v.ea & 64'h3FFF_FFFF_FFFF_FFFF);
        end
        if (v.e_flt) begin
            check(flt_proc == v.e_proc, (v.leaf_at > 4'd4) ? "R9 stage" : "R8 stage", 64'(flt_proc), 64'(v.e_proc));
            check(flt_table == v.e_tbl, "R8 table flag", 64'(flt_table), 64'(v.e_tbl));
            check(flt_bound == v.e_bnd, "R6 bound flag", 64'(flt_bound), 64'(v.e_bnd));
        end else begin
            check(res_addr == exp_addr(v), mode_tag(v), res_addr, exp_addr(v));
            check(res_psize == exp_ps(v), "R7 psize", 64'(res_psize), 64'(exp_ps(v)));
            check(res_perm == exp_perm(v), "R7 perm", 64'(res_perm), 64'(exp_perm(v)));
        end
        @(negedge clk);
        check(!done && !fault && !busy, "R10 single pulse", {61'd0, done, fault, busy}, 64'd0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !fault && !wk_req_valid, "R10 reset state",
              {60'd0, busy, done, fault, wk_req_valid}, 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run_vec(k);

        // R2: real-mode result one cycle after acceptance
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        req_kind = 2'd1; req_hv = 1'b1; req_ir = 1'b1; req_dr = 1'b0;
        req_ea = 64'hABCD_0000_1111_2222; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(done == 1'b1, "R2 latency", 64'(done), 64'd1);
        check(res_addr == 64'h0BCD_0000_1111_2222, "R2 addr", res_addr, 64'h0BCD_0000_1111_2222);
        check(nops == 0, "R2 no walk", 64'(nops), 64'd0);

        // R10: requests while busy are ignored
        @(negedge clk);
        clr = 1'b1; tb_leaf = 2; tb_flt = 15; tb_proc_perm = 3'd7; tb_proc_ps = 6'd20;
        @(negedge clk);
        clr = 1'b0;
        req_kind = 2'd0; req_hv = 1'b1; req_dr = 1'b1; req_ea = 64'h0000_0000_0000_0345;
        req_pid = 20'd1; ptbl_size = 5'd0; req_valid = 1'b1;
        @(negedge clk);
        req_dr = 1'b0; req_ea = 64'h7777_7777_7777_7777;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int cyc = 0;
            while (!(done || fault) && cyc < 200) begin
                @(negedge clk);
                cyc++;
            end
        end
        check(done == 1'b1, "R10 done", 64'(done), 64'd1);
        check(res_addr == 64'h50_0345, "R10 busy ignore addr", res_addr, 64'h50_0345);
        repeat (4) @(negedge clk);
        check(nops == 3 && !busy, "R10 no extra walks", 64'(nops), 64'd3);

        summary();
        $finish;
    end
endmodule